// File: doc/BRIEF.md
# Multi-Queue Manager with Shared Almost-Full Status Bus

This block manages several logical FIFO queues that share one storage array inside a single device. A write port and a read port each run on their own clock. Each port picks its active queue by presenting a device-and-queue address together with an address strobe. Data written while a queue of this device is selected lands in that queue. The read side delivers words in first-word-fall-through fashion: the head word of the selected queue is already waiting on the output before it is consumed.

Every queue keeps an occupancy count on the write side. Its active-low almost-full flag drops once the count reaches the depth minus a programmable offset. Read progress reaches the write side through a two-stage synchronizer, so the flag clears only after a clock-crossing delay. The flags of all queues are offered on a status bus that several devices share. A 3-bit device address, latched with its own strobe, decides which device drives the bus. Ownership changes one write clock after the address is sampled. The old owner lets go on the same edge that the new owner takes over. A discrete almost-full output follows the queue selected on the write port, and stays released until a queue of this device is selected there.

Top module: `mq_flag_top`

## Requirements
- R1: While reset is low, and on the first cycles after it, the status-bus enable, the discrete-flag enable and the read-valid output are all low.
- R2: Write and read addresses carry the device number in the upper 3 bits and the queue number in the lower bits. A device ignores any selection whose device number differs from its own, so it does not store the data or drive its discrete flag.
- R3: A write to a queue that already holds DEPTH words is dropped. The queue's contents and its later read-out are unchanged by it.
- R4: Bus bit q (bit 0 = queue 0) is low exactly when queue q holds at least DEPTH−AF_OFFSET words as seen by the write side. It is high otherwise.
- R5: A status-bus address with a matching device number, sampled on a write-clock edge, makes the bus enable high after the following edge, not earlier. A non-matching address makes the enable low after the following edge.
- R6: When ownership moves to another device, the old owner's enable falls on the same write-clock edge on which the new owner's enable rises. Two devices never drive at once.
- R7: After the read queue is changed, the next word consumed still comes from the previously selected queue. The word after it comes from the new queue.
- R8: When a read takes a queue from DEPTH−AF_OFFSET words to fewer, the flag stays low for at least one further write clock. It then goes high within a few write clocks.
- R9: A write that brings a queue back to DEPTH−AF_OFFSET words drives both its bus bit and the discrete flag low again.
- R10: The discrete-flag enable is low until a queue of this device is selected for writing. It falls again after a selection naming another device. While it is enabled, the discrete flag equals the almost-full state of the selected write queue.
- R11: Words leave each queue in the order in which they were written, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; also clocks the status bus |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, applied in both domains |
| wad_en | input | 1 | Write address strobe |
| waddr | input | 3+QW | Write address: {device, queue} |
| wen | input | 1 | Write enable for the selected queue |
| wdata | input | DW | Write data |
| rad_en | input | 1 | Read address strobe |
| raddr | input | 3+QW | Read address: {device, queue} |
| ren | input | 1 | Consume the word currently on rdata |
| rdata | output | DW | Head word of the read path |
| rvalid | output | 1 | rdata holds a word |
| fs_en | input | 1 | Status-bus address strobe |
| fs_dev | input | 3 | Device selected for the status bus |
| fbus_n | output | NQ | Active-low almost-full flags of all queues (all ones when released) |
| fbus_oe | output | 1 | This device drives the status bus |
| disc_af_n | output | 1 | Active-low almost-full flag of the selected write queue |
| disc_oe | output | 1 | Discrete flag is driven |

## Verification
Two things can land on the same edge. On the status bus, one device releases on the edge where the other starts to drive. The bench puts two instances on one bus and moves ownership between them. It samples both enables after every write clock and requires that never both are high, and that the release and the takeover appear in the same sampled cycle. On the read path, a queue switch can meet a consumption that still belongs to the old queue. The bench switches the read queue while a word is waiting. Its scoreboard then checks that the next word carries the old queue's tag and the one after carries the new tag.

// File: rtl/mq_pkg.sv
// Package: shared constants and types for the multi-queue flag-bus block.
// Assumes the device identifier on every address is exactly DEVW bits wide.
package mq_pkg;
    localparam int DEVW = 3;
    typedef logic [DEVW-1:0] dev_id_t;
endpackage

// File: rtl/mq_ptr_sync.sv
// Module: mq_ptr_sync
// Carries a binary pointer from the source clock into the destination clock.
// The pointer is Gray-coded and registered in the source domain, then passed
// through two destination flops and decoded back to binary.
// Assumes the pointer moves by at most one step per source clock.
module mq_ptr_sync #(
    parameter int W = 4
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] gray_src;
    logic [W-1:0] meta_q;
    logic [W-1:0] gray_dst;

    // Register the Gray form of the pointer in the source domain.
    always_ff @(posedge src_clk) begin
        if (!rst_n) gray_src <= '0;
        else        gray_src <= bin_i ^ (bin_i >> 1);
    end

    // Two flops in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            gray_dst <= '0;
        end else begin
            meta_q   <= gray_src;
            gray_dst <= meta_q;
        end
    end

    // Convert the synchronized Gray value back to binary.
    always_comb begin
        bin_o[W-1] = gray_dst[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ gray_dst[i];
        end
    end
endmodule

// File: rtl/mq_store.sv
// Module: mq_store
// Shared storage for all queues: one write port on the write clock and an
// asynchronous read port. Queue q owns rows q*DEPTH .. q*DEPTH+DEPTH-1.
// Assumes NQ and DEPTH are powers of two.
module mq_store #(
    parameter int NQ    = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int QW   = $clog2(NQ),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [QW-1:0] wq,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [QW-1:0] rq,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem [NQ*DEPTH];

    // Store one word at the write pointer of the selected queue.
    always_ff @(posedge wclk) begin
        if (we) mem[{wq, wa}] <= wd;
    end

    // Present the word at the read pointer of the selected read queue.
    assign rd = mem[{rq, ra}];
endmodule

// File: rtl/mq_wr_side.sv
// Module: mq_wr_side
// Write-clock side: latches the write queue selection, keeps one write
// pointer per queue, and compares it with the synchronized read pointer
// to find each queue's occupancy, full state and active-low almost-full flag.
// Assumes rptr_sync lags the true read pointer (so the occupancy can only
// be over-estimated).
module mq_wr_side
    import mq_pkg::*;
#(
    parameter int      NQ        = 4,
    parameter int      DEPTH     = 8,
    parameter int      AF_OFFSET = 2,
    parameter dev_id_t DEV_ID    = '0,
    localparam int     QW        = $clog2(NQ),
    localparam int     AW        = $clog2(DEPTH),
    localparam int     PW        = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_en,
    input  dev_id_t                sel_dev,
    input  logic [QW-1:0]          sel_q,
    input  logic                   wen,
    input  logic [NQ-1:0][PW-1:0]  rptr_sync,
    output logic [NQ-1:0][PW-1:0]  wptr,
    output logic                   mem_we,
    output logic [QW-1:0]          mem_q,
    output logic [AW-1:0]          mem_addr,
    output logic [NQ-1:0]          af_n,
    output logic                   cur_valid,
    output logic [QW-1:0]          cur_q
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] AF_LVL  = PW'(DEPTH - AF_OFFSET);
    localparam logic [PW-1:0] ONE_P   = PW'(1);

    logic [PW-1:0] occ  [NQ];
    logic [NQ-1:0] full;
    logic          accept;

    // Latch the write queue selection when the address strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_q     <= '0;
        end else if (sel_en) begin
            cur_valid <= (sel_dev == DEV_ID);
            cur_q     <= sel_q;
        end
    end

    // Occupancy, full state and almost-full flag of each queue.
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            occ[q]  = wptr[q] - rptr_sync[q];
            full[q] = (occ[q] == DEPTH_P);
            af_n[q] = !(occ[q] >= AF_LVL);
        end
    end

    // A write is taken only for a selected queue of this device with room left.
    assign accept   = wen && cur_valid && !full[cur_q];
    assign mem_we   = accept;
    assign mem_q    = cur_q;
    assign mem_addr = wptr[cur_q][AW-1:0];

    // Advance the write pointer of the queue that took the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (accept && (cur_q == QW'(q))) wptr[q] <= wptr[q] + ONE_P;
            end
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            occ[g] <= DEPTH_P);
        p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            full[g] |=> wptr[g] == $past(wptr[g]));
    end
endmodule

// File: rtl/mq_rd_side.sv
// Module: mq_rd_side
// Read-clock side: latches the read queue selection, keeps one read pointer
// per queue and runs a first-word-fall-through output register. A word counts
// as read when it is loaded into the output register. So after a queue switch,
// the word already held there still leaves first.
// Assumes wptr_sync lags the true write pointer.
module mq_rd_side
    import mq_pkg::*;
#(
    parameter int      NQ     = 4,
    parameter int      DEPTH  = 8,
    parameter int      DW     = 8,
    parameter dev_id_t DEV_ID = '0,
    localparam int     QW     = $clog2(NQ),
    localparam int     AW     = $clog2(DEPTH),
    localparam int     PW     = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_en,
    input  dev_id_t                sel_dev,
    input  logic [QW-1:0]          sel_q,
    input  logic                   ren,
    input  logic [NQ-1:0][PW-1:0]  wptr_sync,
    input  logic [DW-1:0]          mem_rd,
    output logic [NQ-1:0][PW-1:0]  rptr,
    output logic [QW-1:0]          mem_q,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          dout,
    output logic                   dvalid
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] ONE_P   = PW'(1);

    logic          cur_valid;
    logic [QW-1:0] cur_q;
    logic [NQ-1:0] empty;
    logic          pop;
    logic          load;

    // Latch the read queue selection when the address strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_q     <= '0;
        end else if (sel_en) begin
            cur_valid <= (sel_dev == DEV_ID);
            cur_q     <= sel_q;
        end
    end

    // Empty state of each queue as seen from the read side.
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            empty[q] = (rptr[q] == wptr_sync[q]);
        end
    end

    assign pop      = ren && dvalid;
    assign load     = (!dvalid || pop) && cur_valid && !empty[cur_q];
    assign mem_q    = cur_q;
    assign mem_addr = rptr[cur_q][AW-1:0];

    // Fall-through output register: refill when empty or when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else if (load) begin
            dout   <= mem_rd;
            dvalid <= 1'b1;
        end else if (pop) begin
            dvalid <= 1'b0;
        end
    end

    // Advance the read pointer of the queue that supplied the loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (load && (cur_q == QW'(q))) rptr[q] <= rptr[q] + ONE_P;
            end
        end
    end

    p_fwft_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && !ren) |=> (dvalid && $stable(dout)));

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wptr_sync[g] - rptr[g]) <= DEPTH_P);
    end
endmodule

// File: rtl/mq_flag_bus.sv
// Module: mq_flag_bus
// Status-bus ownership on the write clock. The bus address is latched with
// its strobe. One edge later the enable and the flag snapshot follow the
// latched match. A released bus reads all ones with the enable low.
// Assumes all devices on the bus see the same strobe and address.
module mq_flag_bus
    import mq_pkg::*;
#(
    parameter int      NQ     = 4,
    parameter dev_id_t DEV_ID = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_en,
    input  dev_id_t       fs_dev,
    input  logic [NQ-1:0] af_n,
    output logic [NQ-1:0] bus_n,
    output logic          bus_oe
);
    logic sel_hit;

    // Latch whether the bus address names this device.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_hit <= 1'b0;
        else if (fs_en) sel_hit <= (fs_dev == DEV_ID);
    end

    // Drive or release the bus one edge after the selection was latched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_oe <= 1'b0;
            bus_n  <= '1;
        end else begin
            bus_oe <= sel_hit;
            bus_n  <= sel_hit ? af_n : '1;
        end
    end

    p_sel_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_en && fs_dev == DEV_ID) |-> ##2 bus_oe);
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_en && fs_dev != DEV_ID) |-> ##2 !bus_oe);
    p_released_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_n == '1));
endmodule

// File: rtl/mq_flag_top.sv
// Module: mq_flag_top
// Multi-queue manager. It connects the write side, read side, shared
// storage, two banks of pointer synchronizers and the status-bus driver.
// It also produces the discrete almost-full flag of the selected write queue.
// Assumes rst_n is held low for several edges of both clocks.
module mq_flag_top
    import mq_pkg::*;
#(
    parameter int      NQ        = 4,
    parameter int      DEPTH     = 8,
    parameter int      DW        = 8,
    parameter int      AF_OFFSET = 2,
    parameter dev_id_t DEV_ID    = '0,
    localparam int     QW        = $clog2(NQ),
    localparam int     AW        = $clog2(DEPTH),
    localparam int     PW        = AW + 1
) (
    input  logic               wclk,
    input  logic               rclk,
    input  logic               rst_n,
    input  logic               wad_en,
    input  logic [DEVW+QW-1:0] waddr,
    input  logic               wen,
    input  logic [DW-1:0]      wdata,
    input  logic               rad_en,
    input  logic [DEVW+QW-1:0] raddr,
    input  logic               ren,
    output logic [DW-1:0]      rdata,
    output logic               rvalid,
    input  logic               fs_en,
    input  logic [DEVW-1:0]    fs_dev,
    output logic [NQ-1:0]      fbus_n,
    output logic               fbus_oe,
    output logic               disc_af_n,
    output logic               disc_oe
);
    logic [NQ-1:0][PW-1:0] wptr;
    logic [NQ-1:0][PW-1:0] rptr;
    logic [NQ-1:0][PW-1:0] wptr_rd;
    logic [NQ-1:0][PW-1:0] rptr_wr;
    logic                  mem_we;
    logic [QW-1:0]         mem_wq;
    logic [AW-1:0]         mem_wa;
    logic [QW-1:0]         mem_rq;
    logic [AW-1:0]         mem_ra;
    logic [DW-1:0]         mem_rd;
    logic [NQ-1:0]         af_n;
    logic                  wsel_valid;
    logic [QW-1:0]         wsel_q;

    mq_wr_side #(.NQ(NQ), .DEPTH(DEPTH), .AF_OFFSET(AF_OFFSET), .DEV_ID(DEV_ID)) u_wr (
        .clk(wclk), .rst_n(rst_n),
        .sel_en(wad_en), .sel_dev(waddr[DEVW+QW-1:QW]), .sel_q(waddr[QW-1:0]),
        .wen(wen), .rptr_sync(rptr_wr), .wptr(wptr),
        .mem_we(mem_we), .mem_q(mem_wq), .mem_addr(mem_wa),
        .af_n(af_n), .cur_valid(wsel_valid), .cur_q(wsel_q)
    );

    mq_rd_side #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW), .DEV_ID(DEV_ID)) u_rd (
        .clk(rclk), .rst_n(rst_n),
        .sel_en(rad_en), .sel_dev(raddr[DEVW+QW-1:QW]), .sel_q(raddr[QW-1:0]),
        .ren(ren), .wptr_sync(wptr_rd), .mem_rd(mem_rd), .rptr(rptr),
        .mem_q(mem_rq), .mem_addr(mem_ra), .dout(rdata), .dvalid(rvalid)
    );

    mq_store #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW)) u_store (
        .wclk(wclk), .we(mem_we), .wq(mem_wq), .wa(mem_wa), .wd(wdata),
        .rq(mem_rq), .ra(mem_ra), .rd(mem_rd)
    );

    // One synchronizer pair per queue: read pointers forward, write pointers back.
    for (genvar g = 0; g < NQ; g++) begin : g_sync
        mq_ptr_sync #(.W(PW)) u_r2w (
            .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n),
            .bin_i(rptr[g]), .bin_o(rptr_wr[g])
        );
        mq_ptr_sync #(.W(PW)) u_w2r (
            .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n),
            .bin_i(wptr[g]), .bin_o(wptr_rd[g])
        );
    end

    mq_flag_bus #(.NQ(NQ), .DEV_ID(DEV_ID)) u_bus (
        .clk(wclk), .rst_n(rst_n), .fs_en(fs_en), .fs_dev(fs_dev),
        .af_n(af_n), .bus_n(fbus_n), .bus_oe(fbus_oe)
    );

    // Discrete flag follows the selected write queue; released otherwise.
    assign disc_oe   = wsel_valid;
    assign disc_af_n = wsel_valid ? af_n[wsel_q] : 1'b1;

    p_disc_release_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        (wad_en && waddr[DEVW+QW-1:QW] != DEV_ID) |=> !disc_oe);
    p_disc_follow_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        (wad_en && waddr[DEVW+QW-1:QW] == DEV_ID) |=> disc_oe);
endmodule

// File: tb/sim_mq_flag_top.sv
// Bench for mq_flag_top: two devices (identifiers 0 and 1) share every input.
// Driver tasks push expected words into per-queue queues. A monitor on the
// read clock pops and compares each word that device 0 hands out.
module sim_mq_flag_top;
    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wad_en = 1'b0;
    logic [4:0] waddr = '0;
    logic       wen = 1'b0;
    logic [7:0] wdata = '0;
    logic       rad_en = 1'b0;
    logic [4:0] raddr = '0;
    logic       ren = 1'b0;
    logic       fs_en = 1'b0;
    logic [2:0] fs_dev = '0;

    logic [7:0] rdata0, rdata1;
    logic       rvalid0, rvalid1;
    logic [3:0] fbus0, fbus1;
    logic       oe0, oe1;
    logic       daf0, daf1;
    logic       doe0, doe1;

    int checks = 0;
    int errors = 0;
    int both_drive = 0;
    int seq [4];
    logic [7:0] expq [4][$];
    int src_log [$];
    int consumed = 0;

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #15 rclk = ~rclk;
    end

    mq_flag_top #(.DEV_ID(3'd0)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wad_en(wad_en), .waddr(waddr),
        .wen(wen), .wdata(wdata), .rad_en(rad_en), .raddr(raddr), .ren(ren),
        .rdata(rdata0), .rvalid(rvalid0), .fs_en(fs_en), .fs_dev(fs_dev),
        .fbus_n(fbus0), .fbus_oe(oe0), .disc_af_n(daf0), .disc_oe(doe0)
    );

    mq_flag_top #(.DEV_ID(3'd1)) u1 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wad_en(wad_en), .waddr(waddr),
        .wen(wen), .wdata(wdata), .rad_en(rad_en), .raddr(raddr), .ren(ren),
        .rdata(rdata1), .rvalid(rvalid1), .fs_en(fs_en), .fs_dev(fs_dev),
        .fbus_n(fbus1), .fbus_oe(oe1), .disc_af_n(daf1), .disc_oe(doe1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare every consumed word of device 0 with the scoreboard.
    always @(negedge rclk) begin
        if (rst_n && ren && rvalid0) begin
            automatic int src = int'(rdata0[7:6]);
            src_log.push_back(src);
            if (expq[src].size() == 0) begin
                chk(1'b0, "R11 unexpected word", int'(rdata0), -1);
            end else begin
                automatic logic [7:0] e = expq[src].pop_front();
                chk(rdata0 == e, "R11 order", int'(rdata0), int'(e));
            end
            consumed++;
        end
    end

    // Bus watcher for R6: never two drivers.
    always @(negedge wclk) begin
        if (rst_n && oe0 && oe1) both_drive++;
    end

    task automatic wsel(input int dev, input int q);
        @(posedge wclk); #1;
        wad_en = 1'b1; waddr = {dev[2:0], q[1:0]};
        @(posedge wclk); #1;
        wad_en = 1'b0;
    endtask

    task automatic wr(input int q, input int n, input int nacc);
        for (int i = 0; i < n; i++) begin
            @(posedge wclk); #1;
            wen = 1'b1;
            wdata = {q[1:0], 6'(seq[q])};
            if (i < nacc) expq[q].push_back(wdata);
            seq[q]++;
        end
        @(posedge wclk); #1;
        wen = 1'b0;
    endtask

    task automatic bsel(input int dev);
        @(posedge wclk); #1;
        fs_en = 1'b1; fs_dev = dev[2:0];
        @(posedge wclk); #1;
        fs_en = 1'b0;
    endtask

    task automatic rsel(input int dev, input int q);
        @(posedge rclk); #1;
        rad_en = 1'b1; raddr = {dev[2:0], q[1:0]};
        @(posedge rclk); #1;
        rad_en = 1'b0;
    endtask

    task automatic pop(input int n);
        automatic int target = consumed + n;
        @(posedge rclk); #1;
        ren = 1'b1;
        do @(posedge rclk); while (consumed < target);
        #1 ren = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (50000) @(posedge wclk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        automatic int n;
        for (int q = 0; q < 4; q++) seq[q] = 0;

        // R1: state during reset.
        repeat (4) @(negedge wclk);
        chk(!oe0 && !oe1, "R1 bus enable in reset", int'(oe0), 0);
        chk(!doe0 && !doe1, "R1 discrete enable in reset", int'(doe0), 0);
        chk(!rvalid0 && !rvalid1, "R1 read valid in reset", int'(rvalid0), 0);
        @(posedge wclk); #1 rst_n = 1'b1;
        repeat (2) @(negedge wclk);
        chk(!oe0 && !doe0 && !rvalid0, "R1 idle after reset", int'(oe0), 0);

        // R5: ownership appears one edge after the address is latched.
        bsel(0);
        @(negedge wclk);
        chk(oe0 == 1'b0, "R5 not in latch cycle", int'(oe0), 0);
        @(negedge wclk);
        chk(oe0 == 1'b1, "R5 drives next cycle", int'(oe0), 1);
        chk(fbus0 == 4'hF, "R4 empty queues not almost full", int'(fbus0), 15);

        // R10: discrete flag released until a write queue of this device is chosen.
        chk(doe0 == 1'b0, "R10 released before selection", int'(doe0), 0);
        wsel(0, 0);
        @(negedge wclk);
        chk(doe0 == 1'b1 && daf0 == 1'b1, "R10 enabled after selection", int'({doe0, daf0}), 3);
        chk(doe1 == 1'b0, "R2 other device ignores selection", int'(doe1), 0);

        // R4/R9: the threshold is DEPTH-AF_OFFSET = 6 words.
        wr(0, 5, 5);
        repeat (3) @(negedge wclk);
        chk(fbus0[0] == 1'b1 && daf0 == 1'b1, "R4 five words not almost full", int'({fbus0[0], daf0}), 3);
        wr(0, 1, 1);
        repeat (3) @(negedge wclk);
        chk(fbus0[0] == 1'b0 && daf0 == 1'b0, "R9 sixth word almost full", int'({fbus0[0], daf0}), 0);
        chk(fbus0[3:1] == 3'b111, "R4 other queues clear", int'(fbus0[3:1]), 7);

        // R8: the fall-through load of queue 0 reads at the boundary.
        rsel(0, 0);
        n = 0;
        while (!rvalid0 && n < 20) begin
            @(negedge rclk);
            n++;
        end
        chk(rvalid0 == 1'b1, "R8 word fell through", int'(rvalid0), 1);
        @(negedge wclk);
        chk(fbus0[0] == 1'b0 && daf0 == 1'b0, "R8 flag held through crossing", int'({fbus0[0], daf0}), 0);
        repeat (6) @(negedge wclk);
        chk(fbus0[0] == 1'b1 && daf0 == 1'b1, "R8 flag cleared after crossing", int'({fbus0[0], daf0}), 3);

        // R9: one more write brings queue 0 back to the boundary.
        wr(0, 1, 1);
        repeat (3) @(negedge wclk);
        chk(fbus0[0] == 1'b0 && daf0 == 1'b0, "R9 reasserted after write", int'({fbus0[0], daf0}), 0);

        // R7: a switch of the read queue lets one more old word out first.
        wsel(0, 1);
        wr(1, 2, 2);
        repeat (10) @(negedge wclk);
        rsel(0, 1);
        pop(2);
        n = src_log.size();
        chk(src_log[n-2] == 0, "R7 first word from old queue", src_log[n-2], 0);
        chk(src_log[n-1] == 1, "R7 second word from new queue", src_log[n-1], 1);

        // R3: the ninth write into queue 2 is dropped.
        wsel(0, 2);
        wr(2, 9, 8);
        repeat (4) @(negedge wclk);
        chk(fbus0[2] == 1'b0, "R3 full queue flagged", int'(fbus0[2]), 0);
        rsel(0, 2);
        pop(9);
        repeat (10) @(negedge rclk);
        chk(rvalid0 == 1'b0, "R3 dropped word never read", int'(rvalid0), 0);
        chk(expq[2].size() == 0, "R3 all stored words read", expq[2].size(), 0);

        // R6: handover between devices 0 and 1 on one edge.
        bsel(1);
        @(negedge wclk);
        chk(oe0 == 1'b1 && oe1 == 1'b0, "R6 old owner before handover", int'({oe0, oe1}), 2);
        @(negedge wclk);
        chk(oe0 == 1'b0 && oe1 == 1'b1, "R6 handover on the same edge", int'({oe0, oe1}), 1);
        chk(fbus1 == 4'hF, "R2 other device holds no words", int'(fbus1), 15);
        chk(fbus0 == 4'hF, "R6 released bus reads all ones", int'(fbus0), 15);
        chk(rvalid1 == 1'b0 && doe1 == 1'b0, "R2 other device idle", int'({rvalid1, doe1}), 0);

        // R5: an address naming no present device leaves the bus undriven.
        bsel(5);
        repeat (2) @(negedge wclk);
        chk(!oe0 && !oe1, "R5 nobody drives", int'({oe0, oe1}), 0);
        chk(both_drive == 0, "R6 never two drivers", both_drive, 0);

        // R10: selecting another device for writes releases the discrete flag.
        wsel(3, 0);
        @(negedge wclk);
        chk(doe0 == 1'b0 && daf0 == 1'b1, "R10 released after foreign selection", int'({doe0, daf0}), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule